// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits next to a processor whose bus runs in multi-master mode, where the processor does not drive its own read and write strobes. It only publishes a three-bit, active-low status code. The decoder samples that code on every clock and finds where each bus cycle begins and ends. It then produces the individual control strobes the rest of the system needs: interrupt acknowledge, I/O read, I/O write, memory read, memory write and instruction fetch. It also drives an address latch pulse, a transceiver direction line, a transceiver enable and a halt indication.

A cycle opens when the status leaves the idle code 111 for any other code. That clock is T1. The code is captured at that point, so the strobes keep their meaning after the processor has already returned the status to idle. The command window then runs until one clock after the status is seen idle again. Wait states simply extend the window, because the status stays active until the processor is allowed to finish.

Top module: `busStatusDecoder`

## Requirements
- R1: The status codes map as follows: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 instruction fetch, 101 memory read, 110 memory write, 111 idle. During a command window only the active-low strobe of the captured code is low, and at most one strobe is ever low.
- R2: Once armed, a sample that is not 111, taken right after a sample of 111, starts a cycle. `ale` is then high for exactly the one clock that follows that edge.
- R3: The strobe goes low one clock after the `ale` clock. It stays low while the status is not 111, and for one further clock after the edge that samples 111, and is then released.
- R4: Any change between non-idle codes during a cycle has no effect on which strobe is driven. The code captured at the start is kept.
- R5: Code 011 raises `haltFlag` over the same window a strobe would use. No strobe goes low and `dataEn` stays low.
- R6: `dirTx` is high from the `ale` clock to the end of the window for the write codes 010 and 110. It is low for every other code and when no cycle is open.
- R7: `dataEn` is high exactly while one command strobe is low.
- R8: While `rst` is high and after it, all strobes are high and `ale`, `haltFlag`, `dirTx` and `dataEn` are low. No cycle starts until a 111 sample has been seen after reset.
- R9: If the status is 111 at the edge that ends the `ale` clock, the cycle is dropped. No strobe is driven.
- R10: If a single 111 sample separates two cycles, the old strobe is released at the same edge that starts the new `ale` pulse, and the new code is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| statusN | input | 3 | Active-low processor bus status code |
| ale | output | 1 | Address latch pulse, high in T1 |
| intaN | output | 1 | Interrupt acknowledge strobe, active low |
| ioRdN | output | 1 | I/O read strobe, active low |
| ioWrN | output | 1 | I/O write strobe, active low |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| codeRdN | output | 1 | Instruction fetch strobe, active low |
| haltFlag | output | 1 | High while a halt cycle window is open |
| dirTx | output | 1 | Transceiver direction, high for writes |
| dataEn | output | 1 | Transceiver enable, high while a strobe is low |

## Verification
The closing of one cycle and the opening of the next can land on the same clock edge. This happens when the processor leaves the status idle for only one sample between two cycles. At that edge the old strobe must be released while `ale` rises and the new code is captured. The bench provokes this with hand-written back-to-back sequences that mix read and write codes, and also in a long stretch of random status traffic. It judges every clock against a behavioural model, so a strobe that lingers into the new `ale` clock or a direction line that keeps the old code's value is caught.

// File: rtl/busCmdPkg.sv
package busCmdPkg;
  localparam int STATUS_W  = 3;
  localparam int NUM_CODES = 1 << STATUS_W;
  localparam logic [STATUS_W-1:0] CODE_IDLE = '1;

  // Code values are set by the processor's status encoding
  localparam logic [STATUS_W-1:0] CODE_INTA  = 3'd0;
  localparam logic [STATUS_W-1:0] CODE_IORD  = 3'd1;
  localparam logic [STATUS_W-1:0] CODE_IOWR  = 3'd2;
  localparam logic [STATUS_W-1:0] CODE_HALT  = 3'd3;
  localparam logic [STATUS_W-1:0] CODE_FETCH = 3'd4;
  localparam logic [STATUS_W-1:0] CODE_MEMRD = 3'd5;
  localparam logic [STATUS_W-1:0] CODE_MEMWR = 3'd6;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_TAIL
  } phaseT;

  typedef struct packed {
    logic loadCode;
    logic addrPhase;
    logic cmdWindow;
    logic inCycle;
  } ctrlStrobesT;

  function automatic logic isWriteCode(input logic [STATUS_W-1:0] code);
    return (code == CODE_IOWR) || (code == CODE_MEMWR);
  endfunction
endpackage

// File: rtl/busStatusCtrl.sv
module busStatusCtrl
  import busCmdPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [STATUS_W-1:0] statusN,
  output ctrlStrobesT         ctrl
);
  phaseT phase, phaseNext;
  logic armed;
  logic [STATUS_W-1:0] lastStatus;
  logic isIdle, startSeen, loadCode;

  assign isIdle    = (statusN == CODE_IDLE);
  assign startSeen = armed && (lastStatus == CODE_IDLE) && !isIdle;

  always_comb begin
    phaseNext = phase;
    loadCode  = 1'b0;
    case (phase)
      PH_IDLE: if (startSeen) begin
        phaseNext = PH_ADDR;
        loadCode  = 1'b1;
      end
      PH_ADDR: phaseNext = isIdle ? PH_IDLE : PH_CMD;
      PH_CMD:  if (isIdle) phaseNext = PH_TAIL;
      PH_TAIL: if (!isIdle) begin
        phaseNext = PH_ADDR;
        loadCode  = 1'b1;
      end else begin
        phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      armed      <= 1'b0;
      lastStatus <= CODE_IDLE;
    end else begin
      phase      <= phaseNext;
      armed      <= armed | isIdle;
      lastStatus <= statusN;
    end
  end

  assign ctrl.loadCode  = loadCode;
  assign ctrl.addrPhase = (phase == PH_ADDR);
  assign ctrl.cmdWindow = (phase == PH_CMD) || (phase == PH_TAIL);
  assign ctrl.inCycle   = (phase != PH_IDLE);

  // R2
  ale_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.addrPhase |=> !ctrl.addrPhase);

  // R8
  no_start_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && phase == PH_IDLE) |=> !ctrl.addrPhase);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.addrPhase && isIdle) |=> !ctrl.cmdWindow && !ctrl.inCycle);

  // R3
  window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CMD && isIdle) |=> ctrl.cmdWindow);
endmodule

// File: rtl/busCmdDatapath.sv
module busCmdDatapath
  import busCmdPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [STATUS_W-1:0] statusN,
  input  ctrlStrobesT         ctrl,
  output logic                ale,
  output logic                intaN,
  output logic                ioRdN,
  output logic                ioWrN,
  output logic                memRdN,
  output logic                memWrN,
  output logic                codeRdN,
  output logic                haltFlag,
  output logic                dirTx,
  output logic                dataEn
);
  logic [STATUS_W-1:0]  codeReg;
  logic [NUM_CODES-1:0] codeHot;

  always_ff @(posedge clk) begin
    if (rst)                codeReg <= CODE_IDLE;
    else if (ctrl.loadCode) codeReg <= statusN;
  end

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_decode
    assign codeHot[g] = ctrl.cmdWindow && (codeReg == STATUS_W'(g));
  end

  assign ale      = ctrl.addrPhase;
  assign intaN    = !codeHot[CODE_INTA];
  assign ioRdN    = !codeHot[CODE_IORD];
  assign ioWrN    = !codeHot[CODE_IOWR];
  assign memRdN   = !codeHot[CODE_MEMRD];
  assign memWrN   = !codeHot[CODE_MEMWR];
  assign codeRdN  = !codeHot[CODE_FETCH];
  assign haltFlag = codeHot[CODE_HALT];
  assign dirTx    = ctrl.inCycle && isWriteCode(codeReg);
  assign dataEn   = ctrl.cmdWindow && (codeReg != CODE_HALT);

  logic [5:0] strobesN;
  assign strobesN = {intaN, ioRdN, ioWrN, memRdN, memWrN, codeRdN};

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~strobesN));

  // R7
  den_match_chk: assert property (@(posedge clk) disable iff (rst)
    dataEn |-> !(&strobesN));

  // R4
  code_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.cmdWindow && $past(ctrl.cmdWindow)) |-> $stable(codeReg));

  // R5
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    haltFlag |-> (!dataEn && (&strobesN)));
endmodule

// File: rtl/busStatusDecoder.sv
module busStatusDecoder
  import busCmdPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [STATUS_W-1:0] statusN,
  output logic                ale,
  output logic                intaN,
  output logic                ioRdN,
  output logic                ioWrN,
  output logic                memRdN,
  output logic                memWrN,
  output logic                codeRdN,
  output logic                haltFlag,
  output logic                dirTx,
  output logic                dataEn
);
  ctrlStrobesT ctrl;

  busStatusCtrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .statusN (statusN),
    .ctrl    (ctrl)
  );

  busCmdDatapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .statusN  (statusN),
    .ctrl     (ctrl),
    .ale      (ale),
    .intaN    (intaN),
    .ioRdN    (ioRdN),
    .ioWrN    (ioWrN),
    .memRdN   (memRdN),
    .memWrN   (memWrN),
    .codeRdN  (codeRdN),
    .haltFlag (haltFlag),
    .dirTx    (dirTx),
    .dataEn   (dataEn)
  );
endmodule

// File: tb/busStatusDecoder_bench.sv
`timescale 1ns/1ps
module busStatusDecoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] statusN = 3'b111;
  logic ale, intaN, ioRdN, ioWrN, memRdN, memWrN, codeRdN, haltFlag, dirTx, dataEn;

  always #2 clk = ~clk;

  busStatusDecoder u_busStatusDecoder (
    .clk(clk), .rst(rst), .statusN(statusN),
    .ale(ale), .intaN(intaN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .memRdN(memRdN), .memWrN(memWrN), .codeRdN(codeRdN),
    .haltFlag(haltFlag), .dirTx(dirTx), .dataEn(dataEn)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R8";

  // Behavioural reference: 0 idle, 1 latch clock, 2 active, 3 one-clock tail
  int mPhase = 0;
  int mCode = 7;
  int mLast = 7;
  bit mArmed = 0;

  task automatic modelStep(input int s, input bit inReset);
    if (inReset) begin
      mPhase = 0; mArmed = 0; mLast = 7;
      return;
    end
    if (mPhase == 0) begin
      if (mArmed && mLast == 7 && s != 7) begin mPhase = 1; mCode = s; end
    end else if (mPhase == 1) begin
      mPhase = (s == 7) ? 0 : 2;
    end else if (mPhase == 2) begin
      if (s == 7) mPhase = 3;
    end else begin
      if (s != 7) begin mPhase = 1; mCode = s; end
      else mPhase = 0;
    end
    if (s == 7) mArmed = 1;
    mLast = s;
  endtask

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit act;
    act = (mPhase >= 2);
    chk("R2 ale", ale, mPhase == 1);
    chk("R1 intaN", intaN, !(act && mCode == 0));
    chk("R1 ioRdN", ioRdN, !(act && mCode == 1));
    chk("R1 ioWrN", ioWrN, !(act && mCode == 2));
    chk("R3 codeRdN", codeRdN, !(act && mCode == 4));
    chk("R3 memRdN", memRdN, !(act && mCode == 5));
    chk("R4 memWrN", memWrN, !(act && mCode == 6));
    chk("R5 haltFlag", haltFlag, act && mCode == 3);
    chk("R6 dirTx", dirTx, (mPhase != 0) && (mCode == 2 || mCode == 6));
    chk("R7 dataEn", dataEn, act && mCode != 3);
  endtask

  // compare at the falling edge, then drive the next sample and advance the model
  task automatic tick(input int s);
    @(negedge clk);
    compareAll();
    statusN = 3'(s);
    modelStep(s, rst);
  endtask

  task automatic runCycle(input int code, input int waits);
    tick(7);
    tick(code);
    for (int w = 0; w < waits; w++) tick(code);
    tick(7);
    tick(7);
  endtask

  initial begin
    // R8: reset with a non-idle status held through release
    statusN = 3'b101;
    modelStep(5, 1);
    repeat (3) tick(5);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) tick(5);
    tick(7);
    tick(5); tick(5); tick(7); tick(7);

    // R1 R3 R5 R6 R7: every code with varying wait states
    curReq = "R1";
    for (int c = 0; c < 7; c++) runCycle(c, c % 3);
    curReq = "R5";
    runCycle(3, 2);

    // R4: status drifts between non-idle codes mid cycle
    curReq = "R4";
    tick(7); tick(6); tick(6); tick(1); tick(0); tick(7); tick(7);
    tick(7); tick(5); tick(2); tick(7); tick(7);

    // R9: idle again right after the latch clock
    curReq = "R9";
    tick(7); tick(6); tick(7); tick(7); tick(7);
    tick(1); tick(7); tick(7);

    // R10: single idle sample between cycles
    curReq = "R10";
    tick(7); tick(2); tick(2); tick(7); tick(5); tick(5); tick(7);
    tick(6); tick(7); tick(0); tick(0); tick(7); tick(7);

    // mid-run reset while a cycle is open
    curReq = "R8";
    tick(7); tick(4); tick(4);
    @(negedge clk);
    compareAll();
    rst = 1'b1;
    modelStep(4, 1);
    tick(4);
    @(negedge clk);
    rst = 1'b0;
    tick(4); tick(4); tick(7);

    // random traffic, biased toward idle
    curReq = "R10";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 11);
      tick(r > 7 ? 7 : r);
    end
    tick(7); tick(7);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule